// File: doc/BRIEF.md
# Spread-Spectrum Fractional Divide-Word Modulator

This block sits in front of the feedback divider of a fractional-N synthesizer. It sweeps the divide word slowly around a nominal value, so that the synthesized clock's energy is spread over a band of frequencies and the peak emission at any one frequency is lower. Every clock derived from the same loop therefore gets the same relative deviation. The sweep is produced purely in the digital word, so its depth and rate do not drift with process, voltage or temperature.

Software supplies the nominal word (integer plus fraction), a spread depth in tenths of a percent, and a sweep period counted in reference ticks. It also selects either a symmetric (center) or a below-nominal (down) placement, and either a straight triangle or a shaped profile that lingers at the frequency extremes. A separate mode flag hands the divide word over to a voltage-controlled frequency shift function. While that flag is set the sweep is switched off, because the two modulations cannot be combined. Configuration is sampled only at a sweep boundary, so a sweep in progress never jumps.

Top module: `ssc_frac_mod`

## Requirements
- R1: While `rst_n` is low at a clock edge, `div_word` becomes 0 and the sweep is idle with phase 0. The first edge after release loads `div_word` with `nom_word`.
- R2: A `spread_code` value from 1 to 50 selects a deviation of code × 0.1 %. Every other value (0, or 51 to 63) is treated as zero depth, and the output then stays exactly at the latched nominal word for the whole sweep.
- R3: The `period` input is clamped to the range from floor(REF_KHZ/60) to floor(REF_KHZ/30) reference ticks. The half period H is floor(clamped/2), and one sweep lasts 2·H ticks.
- R4: Within a sweep the phase p runs 1, 2, …, H, H−1, …, 1, 0. The next tick at p = 0 is a boundary. The normalized phase is u = floor(p·2^SHAPE_W / H). With `nonlin_mode` at 0 the profile value s equals u.
- R5: With `nonlin_mode` at 1 (SHAPE_W = 8), s = 256 when u = 256. Otherwise s = T(k) + floor((T(k+1) − T(k))·f / 16), where k = floor(u/16), f = u mod 16 and T(k) = floor((48k² − 2k³)·256 / 4096). T rises from 0 to 256 and is flat at both ends.
- R6: The deviation is dev = floor(N·C·s / (1000·2^SHAPE_W)). Here N is the latched nominal word and C is the latched code after the R2 filtering.
- R7: With `center_mode` at 0 (down), the output is N − dev. It never exceeds N.
- R8: With `center_mode` at 1 (center), the output is N − floor(N·C/2000) + dev. It never falls below N − floor(N/40).
- R9: `nom_word`, `spread_code`, `period`, `center_mode` and `nonlin_mode` are sampled only on a boundary tick. Changes made in the middle of a sweep have no effect until the next boundary.
- R10: If `en` is low at a boundary tick, the sweep goes idle with phase 0, and `div_word` follows `nom_word` one clock later. Dropping `en` mid-sweep lets the current sweep finish first.
- R11: While `vcfs_mode` is high, `div_word` takes `nom_word` at every clock and the phase is forced to 0 with the sweep idle. After the flag falls, a new sweep can start only at a boundary tick.
- R12: The phase advances only on clock edges where `tick` is high. `div_word` is registered and reflects, one clock later, the state and inputs present before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Reference-tick enable; one sweep step per high cycle |
| en | input | 1 | Spread enable, sampled at sweep boundaries |
| vcfs_mode | input | 1 | Voltage-controlled shift active; suppresses the sweep |
| center_mode | input | 1 | 1 = center placement, 0 = down placement |
| nonlin_mode | input | 1 | 1 = shaped profile, 0 = triangle |
| spread_code | input | 6 | Spread depth in 0.1 % steps, legal 1 to 50 |
| period | input | PER_W | Sweep period in reference ticks, before clamping |
| nom_word | input | INT_W+FRAC_W | Nominal divide word, integer and fraction |
| div_word | output | INT_W+FRAC_W | Modulated divide word |

## Verification
On every cycle the embedded assertions enforce several properties. The phase stays within the half period and moves by exactly one step on each tick. It holds still without a tick and sits at zero when idle, and latched settings do not change in the middle of a sweep. Down placement never rises above nominal, center placement never falls more than 2.5 % below it, and the shift mode passes the nominal word straight through. The exact shape of each sweep, meaning the interpolated profile values, the deviation rounding, the clamping of the period and the deferral of configuration and enable changes to a boundary, can only be shown by the bench. It compares every output word against an arithmetic model across the combinations of code, period, placement and profile.

// File: rtl/ssc_pkg.sv
// Shared constants and the profile breakpoint function for the spread modulator.
// Assumes profile breakpoints are unsigned and fit in 32-bit arithmetic.
package ssc_pkg;
    localparam int CODE_W   = 6;    // spread code width, 0.1 % per step
    localparam int CODE_MAX = 50;   // largest legal spread code (5.0 %)
    localparam int SEG_LOG2 = 4;    // log2 of profile segment count
    localparam int SEG_CNT  = 16;   // profile segments

    // Breakpoint k of the shaped profile, smooth-step curve scaled to 2^sw.
    function automatic int shape_point(input int k, input int sw);
        return ((48 * k * k - 2 * k * k * k) << sw) >> 12;
    endfunction
endpackage

// File: rtl/ssc_phase_gen.sv
// Sweep phase generator: triangle counter over a half period plus the
// configuration latches that are loaded only at a sweep boundary (phase 0).
// Assumes PER_MIN >= 4 so the half period is at least 2.
module ssc_phase_gen
    import ssc_pkg::*;
#(
    parameter int W       = 24,
    parameter int PER_W   = 10,
    parameter int PER_MIN = 416,
    parameter int PER_MAX = 833
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              vcfs_mode,
    input  logic              center_mode,
    input  logic              nonlin_mode,
    input  logic [CODE_W-1:0] spread_code,
    input  logic [PER_W-1:0]  period,
    input  logic [W-1:0]      nom_word,
    output logic              act,
    output logic [PER_W-1:0]  ph,
    output logic [PER_W-1:0]  h_lat,
    output logic [CODE_W-1:0] code_lat,
    output logic              center_lat,
    output logic              nonlin_lat,
    output logic [W-1:0]      nom_lat
);
    localparam logic [PER_W-1:0]  P_LO   = PER_W'(PER_MIN);
    localparam logic [PER_W-1:0]  P_HI   = PER_W'(PER_MAX);
    localparam logic [CODE_W-1:0] C_MAX  = CODE_W'(CODE_MAX);

    logic [PER_W-1:0]  per_clamped;
    logic [CODE_W-1:0] code_legal;
    logic              up;

    // Clamp the requested period into the legal modulation-rate window.
    always_comb begin
        if (period < P_LO)      per_clamped = P_LO;
        else if (period > P_HI) per_clamped = P_HI;
        else                    per_clamped = period;
    end

    // Map out-of-range spread codes to zero depth.
    always_comb begin
        code_legal = (spread_code != '0 && spread_code <= C_MAX) ? spread_code : '0;
    end

    // Advance the triangle phase on ticks and latch configuration at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act        <= 1'b0;
            up         <= 1'b0;
            ph         <= '0;
            h_lat      <= '0;
            code_lat   <= '0;
            center_lat <= 1'b0;
            nonlin_lat <= 1'b0;
            nom_lat    <= '0;
        end else if (vcfs_mode) begin
            act <= 1'b0;
            up  <= 1'b0;
            ph  <= '0;
        end else if (tick) begin
            if (ph == '0) begin
                h_lat      <= per_clamped >> 1;
                code_lat   <= code_legal;
                center_lat <= center_mode;
                nonlin_lat <= nonlin_mode;
                nom_lat    <= nom_word;
                act        <= en;
                up         <= en;
                ph         <= en ? PER_W'(1) : '0;
            end else if (up) begin
                ph <= ph + 1'b1;
                if (ph + 1'b1 == h_lat) up <= 1'b0;
            end else begin
                ph <= ph - 1'b1;
            end
        end
    end

    AST_PH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ph <= h_lat);                                                          // R3
    AST_IDLE_PH: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> ph == '0);                                                    // R10
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ph != '0 |=> $stable(code_lat) && $stable(h_lat) && $stable(nom_lat)); // R9
    AST_PH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !vcfs_mode && ph != '0) |=>
            (ph == $past(ph) + PER_W'(1) || ph == $past(ph) - PER_W'(1)));     // R12
    AST_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !vcfs_mode) |=> $stable(ph));                                // R12
endmodule

// File: rtl/ssc_shaper.sv
// Profile shaper: normalizes the phase to 0..2^SW and optionally passes it
// through a 16-segment piecewise-linear smooth-step table.
// Assumes SW >= 5 and h_lat nonzero whenever the sweep is active.
module ssc_shaper
    import ssc_pkg::*;
#(
    parameter int PER_W = 10,
    parameter int SW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] ph,
    input  logic [PER_W-1:0] h_lat,
    input  logic             nonlin_lat,
    output logic [SW:0]      shape
);
    localparam int          FW   = SW - SEG_LOG2;
    localparam logic [SW:0] FULL = (SW+1)'(1) << SW;

    logic [SW:0]         tab [0:SEG_CNT];
    logic [PER_W+SW-1:0] num;
    logic [PER_W+SW-1:0] den;
    logic [SW:0]         u;
    logic [SEG_LOG2-1:0] seg;
    logic [FW-1:0]       frac;
    logic [SW:0]         lo, hi, span, interp;
    logic [SW+FW:0]      prod;

    // Breakpoint table computed at elaboration.
    for (genvar g = 0; g <= SEG_CNT; g++) begin : g_tab
        assign tab[g] = (SW+1)'(shape_point(g, SW));
    end

    // Normalize the phase against the latched half period.
    always_comb begin
        num = {ph, {SW{1'b0}}};
        den = {{SW{1'b0}}, h_lat};
        u   = (h_lat == '0) ? '0 : (SW+1)'(num / den);
    end

    // Interpolate within the selected table segment.
    always_comb begin
        seg    = u[SW-1:FW];
        frac   = u[FW-1:0];
        lo     = tab[{1'b0, seg}];
        hi     = tab[{1'b0, seg} + 5'd1];
        span   = hi - lo;
        prod   = span * frac;
        interp = lo + (SW+1)'(prod >> FW);
    end

    // Choose triangle or shaped profile value.
    always_comb begin
        if (!nonlin_lat) shape = u;
        else if (u[SW])  shape = FULL;
        else             shape = interp;
    end

    AST_SHAPE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        shape <= FULL);                                                        // R5
    AST_SHAPE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ph == '0 |-> shape == '0);                                             // R4
endmodule

// File: rtl/ssc_deviation.sv
// Deviation scaler: multiplies nominal word, spread code and profile value,
// divides by 1000 * 2^SW, and places the result for center or down spread.
// Assumes the nominal word leaves 2.5 % headroom below full scale.
module ssc_deviation
    import ssc_pkg::*;
#(
    parameter int W  = 24,
    parameter int SW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      nom_lat,
    input  logic [CODE_W-1:0] code_lat,
    input  logic [SW:0]       shape,
    input  logic              center_lat,
    output logic [W-1:0]      mod_word
);
    localparam int            HW      = W + CODE_W;
    localparam int            PW      = HW + SW + 1;
    localparam logic [PW-1:0] DIV_DEV = PW'(1000) << SW;
    localparam logic [HW-1:0] DIV_HLF = HW'(2000);

    logic [HW-1:0] nc;
    logic [PW-1:0] prod;
    logic [W-1:0]  dev;
    logic [W-1:0]  half;

    // Fixed-point product and scaling to a divide-word offset.
    always_comb begin
        nc   = HW'(nom_lat) * HW'(code_lat);
        prod = PW'(nc) * PW'(shape);
        dev  = W'(prod / DIV_DEV);
        half = W'(nc / DIV_HLF);
    end

    // Place the sweep symmetrically or entirely below nominal.
    always_comb begin
        if (center_lat) mod_word = nom_lat - half + dev;
        else            mod_word = nom_lat - dev;
    end

    AST_DOWN_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        !center_lat |-> mod_word <= nom_lat);                                  // R7
    AST_CENTER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        center_lat |-> ({1'b0, mod_word} + {1'b0, W'(nom_lat / W'(40))}) >= {1'b0, nom_lat}); // R8
endmodule

// File: rtl/ssc_frac_mod.sv
// Spread-spectrum fractional divide-word modulator, top level.
// Combines phase generator, profile shaper and deviation scaler, and
// registers the output word; the shift mode bypasses the sweep entirely.
// Assumes REF_KHZ is the reference tick rate in kHz and REF_KHZ/60 >= 4.
module ssc_frac_mod #(
    parameter int INT_W   = 8,
    parameter int FRAC_W  = 16,
    parameter int PER_W   = 10,
    parameter int REF_KHZ = 25000,
    parameter int SHAPE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       en,
    input  logic                       vcfs_mode,
    input  logic                       center_mode,
    input  logic                       nonlin_mode,
    input  logic [ssc_pkg::CODE_W-1:0] spread_code,
    input  logic [PER_W-1:0]           period,
    input  logic [INT_W+FRAC_W-1:0]    nom_word,
    output logic [INT_W+FRAC_W-1:0]    div_word
);
    localparam int W       = INT_W + FRAC_W;
    localparam int PER_MIN = REF_KHZ / 60;
    localparam int PER_MAX = REF_KHZ / 30;

    logic                       act;
    logic [PER_W-1:0]           ph, h_lat;
    logic [ssc_pkg::CODE_W-1:0] code_lat;
    logic                       center_lat, nonlin_lat;
    logic [W-1:0]               nom_lat, mod_word;
    logic [SHAPE_W:0]           shape;

    ssc_phase_gen #(.W(W), .PER_W(PER_W), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX)) u_phase (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .vcfs_mode(vcfs_mode),
        .center_mode(center_mode), .nonlin_mode(nonlin_mode),
        .spread_code(spread_code), .period(period), .nom_word(nom_word),
        .act(act), .ph(ph), .h_lat(h_lat), .code_lat(code_lat),
        .center_lat(center_lat), .nonlin_lat(nonlin_lat), .nom_lat(nom_lat)
    );

    ssc_shaper #(.PER_W(PER_W), .SW(SHAPE_W)) u_shape (
        .clk(clk), .rst_n(rst_n), .ph(ph), .h_lat(h_lat),
        .nonlin_lat(nonlin_lat), .shape(shape)
    );

    ssc_deviation #(.W(W), .SW(SHAPE_W)) u_dev (
        .clk(clk), .rst_n(rst_n), .nom_lat(nom_lat), .code_lat(code_lat),
        .shape(shape), .center_lat(center_lat), .mod_word(mod_word)
    );

    // Register the outgoing divide word; bypass the sweep when idle or shifted.
    always_ff @(posedge clk) begin
        if (!rst_n)                  div_word <= '0;
        else if (vcfs_mode || !act)  div_word <= nom_word;
        else                         div_word <= mod_word;
    end

    AST_VCFS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        vcfs_mode |=> div_word == $past(nom_word));                            // R11
    AST_IDLE_NOM: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !vcfs_mode) |=> div_word == $past(nom_word));                 // R10
endmodule

// File: tb/sim_ssc_frac_mod.sv
// Bench: arithmetic model of the sweep compared against every output word.
module sim_ssc_frac_mod;
    localparam int CLK_PERIOD = 10;
    localparam int PER_W      = 6;
    localparam int REF_KHZ    = 600;      // clamp window 10..20 ticks
    localparam int W          = 24;

    logic          clk = 1'b0;
    logic          rst_n, tick, en, vcfs_mode, center_mode, nonlin_mode;
    logic [5:0]    spread_code;
    logic [PER_W-1:0] period;
    logic [W-1:0]  nom_word;
    logic [W-1:0]  div_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state
    longint m_act, m_up, m_ph, m_h, m_code, m_center, m_nonlin, m_nom;

    ssc_frac_mod #(.PER_W(PER_W), .REF_KHZ(REF_KHZ)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .vcfs_mode(vcfs_mode),
        .center_mode(center_mode), .nonlin_mode(nonlin_mode),
        .spread_code(spread_code), .period(period), .nom_word(nom_word),
        .div_word(div_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint tpt(input longint k);
        return ((48*k*k - 2*k*k*k) * 256) / 4096;
    endfunction

    function automatic longint model_out();
        longint u, s, k, f, dev, half;
        if (vcfs_mode || m_act == 0) return longint'(nom_word);
        u = (m_ph * 256) / m_h;
        if (m_nonlin == 0)  s = u;
        else if (u == 256)  s = 256;
        else begin
            k = u / 16; f = u % 16;
            s = tpt(k) + ((tpt(k+1) - tpt(k)) * f) / 16;
        end
        dev  = (m_nom * m_code * s) / 256000;
        half = (m_nom * m_code) / 2000;
        return (m_center != 0) ? (m_nom - half + dev) : (m_nom - dev);
    endfunction

    task automatic model_step();
        longint p;
        if (!rst_n) begin
            m_act = 0; m_up = 0; m_ph = 0; m_h = 0; m_code = 0;
            m_center = 0; m_nonlin = 0; m_nom = 0;
        end else if (vcfs_mode) begin
            m_act = 0; m_up = 0; m_ph = 0;
        end else if (tick) begin
            if (m_ph == 0) begin
                p = period;
                if (p < REF_KHZ/60) p = REF_KHZ/60;
                if (p > REF_KHZ/30) p = REF_KHZ/30;
                m_h      = p / 2;
                m_code   = (spread_code >= 1 && spread_code <= 50) ? spread_code : 0;
                m_center = center_mode;
                m_nonlin = nonlin_mode;
                m_nom    = nom_word;
                m_act    = en;
                m_up     = en;
                m_ph     = en ? 1 : 0;
            end else if (m_up != 0) begin
                m_ph = m_ph + 1;
                if (m_ph == m_h) m_up = 0;
            end else begin
                m_ph = m_ph - 1;
            end
        end
    endtask

    task automatic check(input string tag, input longint got, input longint exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: div_word got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic cyc(input string tag);
        longint e;
        e = rst_n ? model_out() : 0;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag, div_word, e);
    endtask

    task automatic run(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run hung, got 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        int codes_ok [3] = '{1, 25, 50};
        int codes_bad[3] = '{0, 51, 63};
        int pers     [3] = '{10, 15, 20};
        int pers_clp [3] = '{3, 40, 63};
        rst_n = 1'b0; tick = 1'b1; en = 1'b0; vcfs_mode = 1'b0;
        center_mode = 1'b0; nonlin_mode = 1'b0; spread_code = 6'd0;
        period = PER_W'(20); nom_word = 24'h1A_4C00;

        // R1: reset state, then idle pass-through
        run("R1", 3);
        rst_n = 1'b1;
        run("R1", 3);

        // R4 R5 R6 R7 R8: sweep all placements, profiles, codes and periods
        en = 1'b1;
        for (int cm = 0; cm < 2; cm++)
            for (int nl = 0; nl < 2; nl++)
                for (int c = 0; c < 3; c++)
                    for (int p = 0; p < 3; p++) begin
                        string tg;
                        center_mode = cm[0]; nonlin_mode = nl[0];
                        spread_code = 6'(codes_ok[c]); period = PER_W'(pers[p]);
                        nom_word = (c == 1) ? 24'h3F_0A3D : 24'h1A_4C00;
                        tg = {nonlin_mode ? "R5" : "R4", center_mode ? " R8" : " R7", " R6"};
                        run(tg, 44);
                    end

        // R3: periods outside the window are clamped
        spread_code = 6'd40; center_mode = 1'b1; nonlin_mode = 1'b0;
        for (int p = 0; p < 3; p++) begin
            period = PER_W'(pers_clp[p]);
            run("R3", 44);
        end

        // R2: illegal codes give no modulation
        for (int c = 0; c < 3; c++) begin
            spread_code = 6'(codes_bad[c]);
            center_mode = c[0];
            run("R2", 44);
            for (int i = 0; i < 20; i++) begin
                cyc("R2");
                check("R2 flat", div_word, nom_word);
            end
        end

        // R9: mid-sweep configuration and nominal changes take effect later
        spread_code = 6'd50; center_mode = 1'b0; period = PER_W'(20);
        run("R9", 44);
        run("R9", 7);
        spread_code = 6'd10; center_mode = 1'b1; nonlin_mode = 1'b1;
        period = PER_W'(10); nom_word = 24'h22_8000;
        run("R9", 50);

        // R12: sparse ticks and a long hold
        spread_code = 6'd33; nonlin_mode = 1'b0; center_mode = 1'b0; period = PER_W'(14);
        for (int i = 0; i < 120; i++) begin
            tick = (i % 3) != 0;
            cyc("R12");
        end
        tick = 1'b0;
        run("R12", 10);
        tick = 1'b1;

        // R10: enable dropped mid-sweep finishes the sweep then idles
        spread_code = 6'd30; period = PER_W'(20);
        run("R10", 44);
        run("R10", 12);
        en = 1'b0;
        run("R10", 44);
        for (int i = 0; i < 5; i++) begin
            nom_word = nom_word + 24'd11;
            cyc("R10");
            check("R10 idle", div_word, nom_word);
        end

        // R11: voltage-controlled shift overrides the sweep
        en = 1'b1; nonlin_mode = 1'b1;
        run("R11", 15);
        vcfs_mode = 1'b1;
        for (int i = 0; i < 10; i++) begin
            nom_word = nom_word + 24'd37;
            cyc("R11");
            check("R11 pass", div_word, nom_word);
        end
        vcfs_mode = 1'b0;
        run("R11", 44);

        done = 1;
        summary();
        $finish;
    end
endmodule